// File: doc/BRIEF.md
# SPI Master Command-Word Frame Sequencer

This block is the transmit side of an SPI master that is fed a stream of 32-bit command words. Each word holds up to sixteen bits of transmit data and a small set of per-frame controls. The controls choose one of eight programmable timing profiles, the chip-select lines to drive, whether those lines stay low into the next frame, whether the frame closes a queue, and whether a running frame counter is zeroed before the frame shifts.

The sequencer drives the serial clock, the serial output and eight active-low chip-select lines, and it samples the serial input into a right-justified received word. Timing profiles are loaded through a plain write port. A sticky end-of-queue flag and a 16-bit frame counter report progress. A mode input selects master operation; with it low, the per-frame controls are ignored and profile 0 is used.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset all chip-select lines are high, the serial clock and serial output are low, the frame counter and end-of-queue flag are zero, and `cmd_ready` is high.
- R2: A frame shifts N bits, most significant first, taken from the low N bits of word bits 15:0. N is the profile size code plus one, and codes below 3 give N = 4. `rx_data` returns the N sampled input bits right-justified with zeros above them and is flagged by a one-cycle `rx_valid` pulse.
- R3: The clock rests at the profile's polarity bit (`cfg_data` bit 4). With the phase bit (`cfg_data` bit 5) at 0 data is sampled on the first edge of each bit; with it at 1 it is sampled on the second edge. Each clock half-period lasts divider+1 cycles (`cfg_data` bits 13:6).
- R4: Word bits 30:28 pick the timing profile, 0 to 7. A profile is written when `cfg_we` is high, with `cfg_sel` naming it. The layout is `cfg_data` bits 3:0 size code, 4 polarity, 5 phase, 13:6 divider, 21:14 select-to-clock delay and 29:22 clock-to-deselect delay.
- R5: Word bit 16+k enables chip-select k. An enabled line `cs_n[k]` is low for the whole frame, and lines that are not enabled stay high.
- R6: When word bit 31 is 1 and the next word has been accepted by the end of the frame, lines enabled in both frames stay low without a break. When bit 31 is 0, all lines go high for at least one cycle before the next frame.
- R7: When word bit 31 is 1 and no next word has been accepted, the lines stay low through the clock-to-deselect delay and then go high.
- R8: A frame whose word bit 27 is 1 sets `eoq_flag` as it finishes. The flag holds until `eoq_clr` is high, and a set in the same cycle wins over the clear.
- R9: `frame_cnt` adds one for each completed frame, modulo 2^CNT_W.
- R10: A word with bit 26 at 1 zeroes `frame_cnt` before its frame shifts, so the count reads 1 once that frame ends.
- R11: With `master_mode` low, bits 31 and 30:28 and 27 and 26 have no effect: profile 0 is used, the lines are released after the frame, and the flag and counter see only a normal increment.
- R12: `cmd_ready` is high only when the sequencer is idle with nothing pending, or when it is on the last clock edge of a frame. It is low while a frame is being set up or is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_mode | input | 1 | 1: per-frame controls active; 0: controls ignored, profile 0 |
| cfg_we | input | 1 | Profile write strobe |
| cfg_sel | input | 3 | Profile written |
| cfg_data | input | 30 | Profile contents |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word taken this cycle if valid |
| cmd_word | input | 32 | Command word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |
| rx_data | output | 16 | Received word, right-justified |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is new |
| eoq_flag | output | 1 | Sticky end-of-queue status |
| eoq_clr | input | 1 | Clears `eoq_flag` |
| frame_cnt | output | 16 | Completed-frame counter |

## Verification
Every cycle, the assertions check that the clock rests at the active polarity outside the shift phase and that the edge count stays inside the frame. They also check that the counter steps by one per completed frame and is zero after a clear, that the end-of-queue flag is sticky and set on a marked frame, and that an accepted word starts a frame at once. Only the bench scenarios can show the bit order, the right-justified received word under each phase and polarity, the half-period length, the size clamp, the unbroken select across a continuous pair against the gap after a normal frame, and that the controls are ignored outside master mode.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

   localparam int CMD_W  = 32;
   localparam int DATA_W = 16;
   localparam int CS_W   = 8;
   localparam int IDX_W  = 3;
   localparam int SIZE_W = 4;
   localparam int DIV_W  = 8;
   localparam int DLY_W  = 8;
   localparam int BITS_W = 5;
   localparam int MIN_BITS = 4;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_TRAIL
   } seq_state_e;

   // timing profile, MSB first: trail, lead, div, cpha, cpol, size_code
   typedef struct packed {
      logic [DLY_W-1:0]  trail;
      logic [DLY_W-1:0]  lead;
      logic [DIV_W-1:0]  div;
      logic              cpha;
      logic              cpol;
      logic [SIZE_W-1:0] size_code;
   } attr_t;

   localparam int ATTR_W = $bits(attr_t);

   typedef struct packed {
      logic              keep_cs;
      logic [IDX_W-1:0]  idx;
      logic              last_q;
      logic              zero_cnt;
      logic [CS_W-1:0]   sel;
      logic [DATA_W-1:0] data;
   } cmd_t;

   function automatic logic [BITS_W-1:0] frame_bits(input logic [SIZE_W-1:0] code);
      if (code < SIZE_W'(MIN_BITS - 1))
         return BITS_W'(MIN_BITS);
      else
         return BITS_W'(code) + BITS_W'(1);
   endfunction

endpackage

// File: rtl/spi_attr_bank.sv
module spi_attr_bank
   import spi_seq_pkg::*;
#(
   parameter int    NUM_SETS   = 8,
   parameter attr_t RESET_ATTR = '0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_sel,
   input  logic [ATTR_W-1:0]         wr_data,
   output attr_t [NUM_SETS-1:0]      sets
);

   if (NUM_SETS < 1) begin : g_chk_sets
      $error("spi_attr_bank: NUM_SETS must be at least 1");
   end

   for (genvar i = 0; i < NUM_SETS; i++) begin : g_set
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sets[i] <= RESET_ATTR;
         else if (wr_en && (wr_sel == IDX_W'(i)))
            sets[i] <= attr_t'(wr_data);
      end
   end

endmodule

// File: rtl/spi_queue_status.sv
module spi_queue_status
   import spi_seq_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_done,
   input  logic             cnt_clr,
   input  logic             eoq_set,
   input  logic             eoq_clr,
   output logic             eoq_flag,
   output logic [CNT_W-1:0] frame_cnt
);

   if (CNT_W < 2) begin : g_chk_cnt
      $error("spi_queue_status: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         frame_cnt <= '0;
      else if (cnt_clr)
         frame_cnt <= '0;
      else if (frame_done)
         frame_cnt <= frame_cnt + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         eoq_flag <= 1'b0;
      else if (eoq_set)
         eoq_flag <= 1'b1;
      else if (eoq_clr)
         eoq_flag <= 1'b0;
   end

   a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !cnt_clr) |=> (frame_cnt == $past(frame_cnt) + CNT_W'(1)));

   a_r10_zero_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (frame_cnt == '0));

   a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      eoq_set |=> eoq_flag);

   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (eoq_flag && !eoq_clr) |=> eoq_flag);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_seq_pkg::*;
#(
   parameter int NUM_SETS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  master_mode,
   input  logic                  cmd_valid,
   output logic                  cmd_ready,
   input  logic [CMD_W-1:0]      cmd_word,
   input  attr_t [NUM_SETS-1:0]  sets,
   output logic                  sclk,
   output logic                  mosi,
   input  logic                  miso,
   output logic [CS_W-1:0]       cs_n,
   output logic [DATA_W-1:0]     rx_data,
   output logic                  rx_valid,
   output logic                  frame_done,
   output logic                  eoq_hit,
   output logic                  cnt_clr
);

   localparam int TMR_W  = (DIV_W > DLY_W) ? DIV_W : DLY_W;
   localparam int EDGE_W = BITS_W + 1;

   seq_state_e          state;
   logic [TMR_W-1:0]    hcnt;
   logic [EDGE_W-1:0]   ecnt;
   logic [BITS_W-1:0]   nbits;
   logic [DATA_W:0]     sh;
   logic [DATA_W-1:0]   rxsh;
   logic                cur_keep, cur_last, cur_cpol, cur_cpha;
   logic [CS_W-1:0]     cur_sel;
   logic [DIV_W-1:0]    cur_div;
   logic [DLY_W-1:0]    cur_lead, cur_trail;
   cmd_t                pend;
   logic                pend_vld;

   // field decode of the incoming word; per-frame controls gated by mode
   cmd_t                in_cmd;
   logic [1:0]          rsvd_unused;
   assign rsvd_unused     = cmd_word[25:24];
   assign in_cmd.keep_cs  = master_mode & cmd_word[31];
   assign in_cmd.idx      = master_mode ? cmd_word[30:28] : '0;
   assign in_cmd.last_q   = master_mode & cmd_word[27];
   assign in_cmd.zero_cnt = master_mode & cmd_word[26];
   assign in_cmd.sel      = cmd_word[23:16];
   assign in_cmd.data     = cmd_word[15:0];

   logic edge_now, last_edge, trail_done, samp;
   logic load_pend, load_new, do_load;
   cmd_t ld_cmd;
   attr_t ld_attr;
   logic [BITS_W-1:0] ld_bits;
   logic [DATA_W-1:0] aligned;

   assign edge_now   = (state == ST_SHIFT) && (hcnt == TMR_W'(cur_div));
   assign last_edge  = edge_now && (ecnt == ({nbits, 1'b0} - EDGE_W'(1)));
   assign trail_done = (state == ST_TRAIL) && (hcnt == TMR_W'(cur_trail));
   assign samp       = (~ecnt[0]) ^ cur_cpha;

   assign cmd_ready  = !pend_vld && ((state == ST_IDLE) || last_edge);

   assign load_pend  = pend_vld && ((state == ST_IDLE) || (trail_done && cur_keep));
   assign load_new   = (state == ST_IDLE) && !pend_vld && cmd_valid;
   assign do_load    = load_pend || load_new;
   assign ld_cmd     = load_pend ? pend : in_cmd;
   assign ld_attr    = sets[ld_cmd.idx];
   assign ld_bits    = frame_bits(ld_attr.size_code);
   assign aligned    = ld_cmd.data << (BITS_W'(DATA_W) - ld_bits);

   assign cnt_clr    = do_load && ld_cmd.zero_cnt;
   assign frame_done = last_edge;
   assign eoq_hit    = last_edge && cur_last;

   assign mosi = sh[DATA_W];
   assign cs_n = (state == ST_IDLE) ? '1 : ~cur_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         hcnt      <= '0;
         ecnt      <= '0;
         nbits     <= BITS_W'(MIN_BITS);
         sh        <= '0;
         rxsh      <= '0;
         sclk      <= 1'b0;
         cur_keep  <= 1'b0;
         cur_last  <= 1'b0;
         cur_cpol  <= 1'b0;
         cur_cpha  <= 1'b0;
         cur_sel   <= '0;
         cur_div   <= '0;
         cur_lead  <= '0;
         cur_trail <= '0;
         pend      <= '0;
         pend_vld  <= 1'b0;
         rx_data   <= '0;
         rx_valid  <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (do_load) begin
            state     <= ST_LEAD;
            hcnt      <= '0;
            ecnt      <= '0;
            nbits     <= ld_bits;
            sh        <= ld_attr.cpha ? {1'b0, aligned} : {aligned, 1'b0};
            rxsh      <= '0;
            sclk      <= ld_attr.cpol;
            cur_keep  <= ld_cmd.keep_cs;
            cur_last  <= ld_cmd.last_q;
            cur_sel   <= ld_cmd.sel;
            cur_cpol  <= ld_attr.cpol;
            cur_cpha  <= ld_attr.cpha;
            cur_div   <= ld_attr.div;
            cur_lead  <= ld_attr.lead;
            cur_trail <= ld_attr.trail;
            if (load_pend)
               pend_vld <= 1'b0;
         end else begin
            unique case (state)
               ST_LEAD: begin
                  if (hcnt == TMR_W'(cur_lead)) begin
                     state <= ST_SHIFT;
                     hcnt  <= '0;
                  end else begin
                     hcnt <= hcnt + TMR_W'(1);
                  end
               end
               ST_SHIFT: begin
                  if (edge_now) begin
                     hcnt <= '0;
                     sclk <= ~sclk;
                     ecnt <= ecnt + EDGE_W'(1);
                     if (samp)
                        rxsh <= {rxsh[DATA_W-2:0], miso};
                     else
                        sh <= {sh[DATA_W-1:0], 1'b0};
                     if (last_edge) begin
                        state    <= ST_TRAIL;
                        rx_valid <= 1'b1;
                        rx_data  <= samp ? {rxsh[DATA_W-2:0], miso} : rxsh;
                     end
                  end else begin
                     hcnt <= hcnt + TMR_W'(1);
                  end
               end
               ST_TRAIL: begin
                  if (trail_done) begin
                     state <= ST_IDLE;
                     hcnt  <= '0;
                  end else begin
                     hcnt <= hcnt + TMR_W'(1);
                  end
               end
               default: ;
            endcase
            if (last_edge && cmd_valid) begin
               pend     <= in_cmd;
               pend_vld <= 1'b1;
            end
         end
      end
   end

   a_r3_sclk_rest: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_SHIFT) |-> (sclk == cur_cpol));

   a_r2_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT) |-> (ecnt < {nbits, 1'b0}));

   a_r2_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   a_r12_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && (state == ST_IDLE)) |=> (state == ST_LEAD));

   a_r12_busy_in_lead: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LEAD) |-> !cmd_ready);

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
   import spi_seq_pkg::*;
#(
   parameter int NUM_SETS = 8,
   parameter int CNT_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_mode,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_sel,
   input  logic [ATTR_W-1:0] cfg_data,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [CMD_W-1:0]  cmd_word,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [CS_W-1:0]   cs_n,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              eoq_flag,
   input  logic              eoq_clr,
   output logic [CNT_W-1:0]  frame_cnt
);

   if (NUM_SETS != (1 << IDX_W)) begin : g_chk_sets
      $error("spi_cmd_seq: NUM_SETS must match the index field width");
   end
   if (DATA_W + CS_W + 8 != CMD_W) begin : g_chk_word
      $error("spi_cmd_seq: command word layout does not fit CMD_W");
   end

   attr_t [NUM_SETS-1:0] sets;
   logic frame_done, eoq_hit, cnt_clr;

   spi_attr_bank #(.NUM_SETS(NUM_SETS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_data),
      .sets    (sets)
   );

   spi_shift_engine #(.NUM_SETS(NUM_SETS)) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .master_mode (master_mode),
      .cmd_valid   (cmd_valid),
      .cmd_ready   (cmd_ready),
      .cmd_word    (cmd_word),
      .sets        (sets),
      .sclk        (sclk),
      .mosi        (mosi),
      .miso        (miso),
      .cs_n        (cs_n),
      .rx_data     (rx_data),
      .rx_valid    (rx_valid),
      .frame_done  (frame_done),
      .eoq_hit     (eoq_hit),
      .cnt_clr     (cnt_clr)
   );

   spi_queue_status #(.CNT_W(CNT_W)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_done (frame_done),
      .cnt_clr    (cnt_clr),
      .eoq_set    (eoq_hit),
      .eoq_clr    (eoq_clr),
      .eoq_flag   (eoq_flag),
      .frame_cnt  (frame_cnt)
   );

endmodule

// File: tb/sim_spi_cmd_seq.sv
module sim_spi_cmd_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        master_mode = 1'b1;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [29:0] cfg_data = '0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [31:0] cmd_word = '0;
   logic        sclk, mosi, miso;
   logic [7:0]  cs_n;
   logic [15:0] rx_data;
   logic        rx_valid;
   logic        eoq_flag;
   logic        eoq_clr = 1'b0;
   logic [15:0] frame_cnt;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   assign miso = mosi;

   spi_cmd_seq u0 (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
      .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
      .rx_data(rx_data), .rx_valid(rx_valid),
      .eoq_flag(eoq_flag), .eoq_clr(eoq_clr), .frame_cnt(frame_cnt)
   );

   // serial-line monitor, sampled on the falling clk edge
   logic        mon_cpol = 1'b0, mon_cpha = 1'b0;
   int          mon_req = 0, mon_seen = 0;
   int          mon_bits = 0, tog_n = 0, cyc = 0;
   int          tog_t0 = 0, tog_t1 = 0;
   logic [15:0] mon_word = '0;
   logic        prev_sclk = 1'b0;
   logic [7:0]  prev_cs = 8'hFF;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (mon_req != mon_seen) begin
         mon_bits = 0; mon_word = '0; tog_n = 0; mon_seen = mon_req;
      end
      if (sclk !== prev_sclk && prev_cs != 8'hFF) begin
         if (tog_n == 0) tog_t0 = cyc;
         if (tog_n == 1) tog_t1 = cyc;
         tog_n = tog_n + 1;
         if (((sclk ^ mon_cpol) ^ mon_cpha) == 1'b1) begin
            mon_word = {mon_word[14:0], mosi};
            mon_bits = mon_bits + 1;
         end
      end
      prev_sclk = sclk;
      prev_cs = cs_n;
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit cont, input logic [2:0] idx, input bit eoq,
                                      input bit clr, input logic [7:0] pcs, input logic [15:0] d);
      return {cont, idx, eoq, clr, 2'b00, pcs, d};
   endfunction

   task automatic wr_set(input logic [2:0] idx, input logic [7:0] trail, input logic [7:0] lead,
                         input logic [7:0] div, input bit cpha, input bit cpol, input logic [3:0] code);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = idx; cfg_data = {trail, lead, div, cpha, cpol, code};
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic mon_reset(input bit cpol, input bit cpha);
      @(negedge clk);
      mon_cpol = cpol; mon_cpha = cpha; mon_req = mon_req + 1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic send(input logic [31:0] w);
      @(negedge clk);
      cmd_word = w; cmd_valid = 1'b1;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_rx();
      do @(negedge clk); while (!rx_valid);
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!(cs_n == 8'hFF && cmd_ready));
   endtask

   task automatic t_reset();
      check(cs_n == 8'hFF, "R1 cs_n", cs_n, 8'hFF);
      check(sclk == 1'b0, "R1 sclk", sclk, 0);
      check(mosi == 1'b0, "R1 mosi", mosi, 0);
      check(frame_cnt == 0, "R1 frame_cnt", frame_cnt, 0);
      check(eoq_flag == 1'b0, "R1 eoq_flag", eoq_flag, 0);
      check(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
   endtask

   task automatic t_basic();
      mon_reset(0, 0);
      send(mk(0, 3'd1, 0, 0, 8'h04, 16'h12A5));
      check(cs_n == 8'hFB, "R5 only line 2 low", cs_n, 8'hFB);
      check(cmd_ready == 1'b0, "R12 busy during setup", cmd_ready, 0);
      wait_rx();
      check(rx_data == 16'h00A5, "R2 rx 8-bit", rx_data, 16'h00A5);
      wait_idle();
      check(mon_bits == 8, "R4 profile 1 size", mon_bits, 8);
      check(mon_word[7:0] == 8'hA5, "R2 msb first", mon_word, 8'hA5);
      check(cmd_ready == 1'b1, "R12 ready when idle", cmd_ready, 1);
   endtask

   task automatic t_modes();
      mon_reset(1, 1);
      send(mk(0, 3'd2, 0, 0, 8'h01, 16'hC3A1));
      wait_rx();
      check(rx_data == 16'hC3A1, "R3 cpol1 cpha1 rx", rx_data, 16'hC3A1);
      wait_idle();
      check(mon_bits == 16 && mon_word == 16'hC3A1, "R3 cpol1 cpha1 line", mon_word, 16'hC3A1);
      check(sclk == 1'b1, "R3 rest high", sclk, 1);
      mon_reset(0, 1);
      send(mk(0, 3'd3, 0, 0, 8'h01, 16'hFABC));
      wait_rx();
      check(rx_data == 16'h0ABC, "R3 cpha1 12-bit rx", rx_data, 16'h0ABC);
      wait_idle();
      check(mon_bits == 12 && mon_word[11:0] == 12'hABC, "R3 cpha1 line", mon_word, 12'hABC);
      check(sclk == 1'b0, "R3 rest low", sclk, 0);
      mon_reset(0, 0);
      send(mk(0, 3'd4, 0, 0, 8'h01, 16'h0009));
      wait_idle();
      check(tog_t1 - tog_t0 == 4, "R3 half period div 3", tog_t1 - tog_t0, 4);
      check(tog_n == 8, "R3 edge count", tog_n, 8);
   endtask

   task automatic t_clamp();
      mon_reset(0, 0);
      send(mk(0, 3'd5, 0, 0, 8'h80, 16'h00F6));
      check(cs_n == 8'h7F, "R5 line 7", cs_n, 8'h7F);
      wait_rx();
      check(rx_data == 16'h0006, "R2 clamp rx", rx_data, 16'h0006);
      wait_idle();
      check(mon_bits == 4, "R2 clamp to 4 bits", mon_bits, 4);
   endtask

   task automatic t_pair(input bit cont);
      int highs = 0;
      int nrx = 0;
      bit clr_next = 0;
      logic [15:0] last_rx = '0;
      mon_reset(0, 0);
      send(mk(cont, 3'd1, 0, 0, 8'h01, 16'h003C));
      cmd_word = mk(0, 3'd1, 0, 0, 8'h01, 16'h005A);
      cmd_valid = 1'b1;
      while (nrx < 2) begin
         if (cs_n[0]) highs++;
         if (rx_valid) begin
            nrx++;
            last_rx = rx_data;
         end
         if (cmd_valid && cmd_ready) clr_next = 1;
         @(negedge clk);
         if (clr_next) begin
            cmd_valid = 1'b0;
            clr_next = 0;
         end
      end
      if (cont)
         check(highs == 0, "R6 select held across pair", highs, 0);
      else
         check(highs > 0, "R6 select released between frames", highs, 1);
      check(last_rx == 16'h005A, "R6 second frame data", last_rx, 16'h005A);
      wait_idle();
      check(mon_bits == 16 && mon_word == 16'h3C5A, "R6 both frames shifted", mon_word, 16'h3C5A);
   endtask

   task automatic t_cont_tail();
      send(mk(1, 3'd1, 0, 0, 8'h02, 16'h0011));
      wait_rx();
      check(cs_n[1] == 1'b0, "R7 held through trail", cs_n, 8'hFD);
      repeat (4) @(negedge clk);
      check(cs_n == 8'hFF, "R7 released with no next word", cs_n, 8'hFF);
   endtask

   task automatic t_eoq();
      check(eoq_flag == 1'b0, "R8 flag clear before", eoq_flag, 0);
      send(mk(0, 3'd0, 1, 0, 8'h01, 16'h0003));
      wait_idle();
      check(eoq_flag == 1'b1, "R8 flag set", eoq_flag, 1);
      send(mk(0, 3'd0, 0, 0, 8'h01, 16'h0004));
      wait_idle();
      check(eoq_flag == 1'b1, "R8 flag sticky", eoq_flag, 1);
      @(negedge clk) eoq_clr = 1'b1;
      @(negedge clk) eoq_clr = 1'b0;
      check(eoq_flag == 1'b0, "R8 flag cleared", eoq_flag, 0);
   endtask

   task automatic t_counter();
      logic [15:0] c0 = frame_cnt;
      send(mk(0, 3'd0, 0, 0, 8'h01, 16'h0001));
      wait_idle();
      send(mk(0, 3'd0, 0, 0, 8'h01, 16'h0002));
      wait_idle();
      check(frame_cnt == c0 + 16'd2, "R9 two increments", frame_cnt, c0 + 16'd2);
      send(mk(0, 3'd0, 0, 1, 8'h01, 16'h0003));
      wait_idle();
      check(frame_cnt == 16'd1, "R10 cleared then counted", frame_cnt, 1);
   endtask

   task automatic t_slave();
      logic [15:0] c0 = frame_cnt;
      master_mode = 1'b0;
      mon_reset(0, 0);
      send(mk(1, 3'd1, 1, 1, 8'h01, 16'h00A5));
      wait_idle();
      check(mon_bits == 4 && mon_word[3:0] == 4'h5, "R11 profile 0 used", mon_bits, 4);
      check(cs_n == 8'hFF, "R11 select released", cs_n, 8'hFF);
      check(eoq_flag == 1'b0, "R11 no flag", eoq_flag, 0);
      check(frame_cnt == c0 + 16'd1, "R11 no clear", frame_cnt, c0 + 16'd1);
      master_mode = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      wr_set(3'd1, 8'd1, 8'd2, 8'd1, 0, 0, 4'd7);
      wr_set(3'd2, 8'd0, 8'd1, 8'd0, 1, 1, 4'd15);
      wr_set(3'd3, 8'd2, 8'd0, 8'd0, 1, 0, 4'd11);
      wr_set(3'd4, 8'd0, 8'd0, 8'd3, 0, 0, 4'd3);
      wr_set(3'd5, 8'd0, 8'd0, 8'd0, 0, 0, 4'd1);
      t_basic();
      t_modes();
      t_clamp();
      t_pair(1'b1);
      t_pair(1'b0);
      t_cont_tail();
      t_eoq();
      t_counter();
      t_slave();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule